// File: doc/BRIEF.md
# Paired-Access Register File

This block is the general-purpose register file of a small processor. It holds sixteen words, addressed by a 4-bit index. It has two independent read ports and one write port. Register 0 always reads as zero, and no write can change it. Every other register is ordinary storage, including the stack pointer (index 2) and the return-address register (index 1). The write port takes any word, so a jump-and-link can write its link value (pc+1) through the normal write path.

Each port has a mode bit. In word mode a port moves a single register. The word sits in the low half of the double-width data bus, and the upper half reads as zero. In pair mode a port moves an aligned pair as one double-width value: the even register 2k is the low half and register 2k+1 is the high half. The low index bit is ignored in pair mode. Doubleword loads and stores use this mode, so a pair is read, or written on both halves, in a single cycle.

Reads are combinational. Writes happen at the rising clock edge while the write enable is high. A read in the same cycle as a write therefore sees the old contents. The pipeline decides when these signals are presented, so the ports are plain control and data pins with no valid/ready handshake and no back-pressure.

Top module: `pair_regfile`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears every register, so afterwards every word-mode read returns 0.
- R2: With wr_en high and wr_pair low, the rising edge writes wr_data[W-1:0] into register wr_idx (when wr_idx is not 0) and changes no other register.
- R3: With wr_en low, no register changes at the clock edge, whatever the other write inputs are.
- R4: Register 0 reads as 0 at all times, and a word-mode write to index 0 leaves every register unchanged.
- R5: With wr_en and wr_pair high, one edge writes wr_data[W-1:0] into register {wr_idx[3:1],0} and wr_data[2W-1:W] into register {wr_idx[3:1],1}. wr_idx[0] has no effect.
- R6: A pair-mode write to pair 0 (index 0 or 1) updates only register 1, and register 0 stays 0.
- R7: A word-mode read returns register rdN_idx on rdN_data[W-1:0], with rdN_data[2W-1:W] equal to 0.
- R8: A pair-mode read returns {reg[{idx[3:1],1}], reg[{idx[3:1],0}]}, and rdN_idx[0] has no effect. For pair 0 the low half is 0.
- R9: A read in the same cycle as a write to the same register returns the value held before that edge. The new value is visible right after the edge.
- R10: The two read ports are independent: each returns its own index and mode in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd0_idx | input | 4 | Read port 0 register index |
| rd0_pair | input | 1 | Read port 0 mode: 0 word, 1 aligned pair |
| rd0_data | output | 2*DATA_W | Read port 0 data (word mode: upper half 0) |
| rd1_idx | input | 4 | Read port 1 register index |
| rd1_pair | input | 1 | Read port 1 mode: 0 word, 1 aligned pair |
| rd1_data | output | 2*DATA_W | Read port 1 data (word mode: upper half 0) |
| wr_en | input | 1 | Write enable |
| wr_pair | input | 1 | Write mode: 0 word, 1 aligned pair |
| wr_idx | input | 4 | Write register index (bit 0 ignored in pair mode) |
| wr_data | input | 2*DATA_W | Write data (word mode uses low half only) |

## Verification
The assertions run on every cycle. They check the register array against the write inputs: reset clears everything, a disabled write leaves the array stable, word and pair writes land in the right entries one edge later, and the zero entry never gets a write enable. They also check the read ports: the upper half is zero in word mode, and the low half of pair 0 is zero. The bench sweeps every index on both read ports in both modes, for word writes, pair writes with each parity of the index, and writes to index 0. Only these scenarios can show the full contents through the ports, including that neighbouring registers stay untouched, the old-value read in the cycle of a write, and two ports reading different registers at once.

// File: rtl/pair_rf_pkg.sv
package pair_rf_pkg;
  typedef enum logic {
    ACC_WORD = 1'b0,
    ACC_PAIR = 1'b1
  } acc_mode_e;

  function automatic acc_mode_e to_mode(input logic b);
    return b ? ACC_PAIR : ACC_WORD;
  endfunction
endpackage

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int DATA_W = 32,
  parameter int NREG   = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NREG-1:0]             we,
  input  logic [NREG-1:0][DATA_W-1:0] wdata,
  output logic [NREG-1:0][DATA_W-1:0] q
);
  // entry 0 is a constant zero; its enable and data are never stored
  wire unused_zero_lane = we[0] ^ (^wdata[0]);

  assign q[0] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_entry
    logic [DATA_W-1:0] r;
    always_ff @(posedge clk) begin
      if (rst)        r <= '0;
      else if (we[i]) r <= wdata[i];
    end
    assign q[i] = r;
  end

  assert_reset_clears_R1: assert property (@(posedge clk) rst |=> (q == '0));
  assert_zero_never_enabled_R4: assert property (@(posedge clk) disable iff (rst) !we[0]);
endmodule

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  localparam int NREG  = 1 << IDX_W
) (
  input  logic                        wr_en,
  input  pair_rf_pkg::acc_mode_e      mode,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [2*DATA_W-1:0]         wr_data,
  output logic [NREG-1:0]             we,
  output logic [NREG-1:0][DATA_W-1:0] wdata
);
  import pair_rf_pkg::*;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      logic [IDX_W-1:0] ii;
      logic hit;
      ii  = IDX_W'(i);
      hit = (mode == ACC_PAIR) ? (ii[IDX_W-1:1] == wr_idx[IDX_W-1:1])
                               : (ii == wr_idx);
      we[i]    = wr_en && hit && (i != 0);
      wdata[i] = (mode == ACC_PAIR && ii[0]) ? wr_data[2*DATA_W-1:DATA_W]
                                             : wr_data[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  localparam int NREG  = 1 << IDX_W
) (
  input  logic [NREG-1:0][DATA_W-1:0] words,
  input  logic [IDX_W-1:0]            idx,
  input  pair_rf_pkg::acc_mode_e      mode,
  output logic [2*DATA_W-1:0]         data
);
  import pair_rf_pkg::*;

  logic [IDX_W-1:0] even_idx, odd_idx;
  assign even_idx = {idx[IDX_W-1:1], 1'b0};
  assign odd_idx  = {idx[IDX_W-1:1], 1'b1};

  always_comb begin
    if (mode == ACC_PAIR) data = {words[odd_idx], words[even_idx]};
    else                  data = {{DATA_W{1'b0}}, words[idx]};
  end
endmodule

// File: rtl/pair_regfile.sv
module pair_regfile #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [IDX_W-1:0]    rd0_idx,
  input  logic                rd0_pair,
  output logic [2*DATA_W-1:0] rd0_data,
  input  logic [IDX_W-1:0]    rd1_idx,
  input  logic                rd1_pair,
  output logic [2*DATA_W-1:0] rd1_data,
  input  logic                wr_en,
  input  logic                wr_pair,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [2*DATA_W-1:0] wr_data
);
  import pair_rf_pkg::*;
  localparam int NREG = 1 << IDX_W;

  logic [NREG-1:0]             we;
  logic [NREG-1:0][DATA_W-1:0] wdata;
  logic [NREG-1:0][DATA_W-1:0] words;
  logic [IDX_W-1:0]            even_w, odd_w;

  assign even_w = {wr_idx[IDX_W-1:1], 1'b0};
  assign odd_w  = {wr_idx[IDX_W-1:1], 1'b1};

  rf_wr_decode #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dec (
    .wr_en(wr_en), .mode(to_mode(wr_pair)), .wr_idx(wr_idx),
    .wr_data(wr_data), .we(we), .wdata(wdata)
  );

  rf_bank #(.DATA_W(DATA_W), .NREG(NREG)) u_bank (
    .clk(clk), .rst(rst), .we(we), .wdata(wdata), .q(words)
  );

  rf_rd_port #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rd0 (
    .words(words), .idx(rd0_idx), .mode(to_mode(rd0_pair)), .data(rd0_data)
  );

  rf_rd_port #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rd1 (
    .words(words), .idx(rd1_idx), .mode(to_mode(rd1_pair)), .data(rd1_data)
  );

  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(words));
  assert_word_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_pair && wr_idx != '0) |=> (words[$past(wr_idx)] == $past(wr_data[DATA_W-1:0])));
  assert_pair_high_lands_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_pair) |=> (words[$past(odd_w)] == $past(wr_data[2*DATA_W-1:DATA_W])));
  assert_pair_low_lands_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_pair && wr_idx[IDX_W-1:1] != '0) |=> (words[$past(even_w)] == $past(wr_data[DATA_W-1:0])));
  assert_pair0_keeps_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_pair && wr_idx[IDX_W-1:1] == '0) |=> (words[0] == '0));
  assert_word_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (!rd0_pair |-> rd0_data[2*DATA_W-1:DATA_W] == '0) and (!rd1_pair |-> rd1_data[2*DATA_W-1:DATA_W] == '0));
  assert_pair0_low_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rd0_pair && rd0_idx[IDX_W-1:1] == '0) |-> rd0_data[DATA_W-1:0] == '0);
endmodule

// File: tb/pair_regfile_tb.sv
`timescale 1ns/1ps
module pair_regfile_tb_top;
  localparam int W = 32;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst;
  logic [3:0] rd0_idx, rd1_idx, wr_idx;
  logic rd0_pair, rd1_pair, wr_en, wr_pair;
  logic [2*W-1:0] rd0_data, rd1_data, wr_data;

  logic [W-1:0] mdl [N];
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  pair_regfile #(.DATA_W(W), .IDX_W(4)) dut_i (
    .clk(clk), .rst(rst),
    .rd0_idx(rd0_idx), .rd0_pair(rd0_pair), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_pair(rd1_pair), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_pair(wr_pair), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  task automatic check(input string req, input logic [2*W-1:0] got, input logic [2*W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [2*W-1:0] exp_read(input int idx, input bit pair);
    if (pair) return {mdl[idx | 1], mdl[idx & 14]};
    return {{W{1'b0}}, mdl[idx]};
  endfunction

  // sweep every index on both ports, both modes; port 1 reads a different index (R10)
  task automatic sweep(input string req);
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < N; i++) begin
        rd0_idx = 4'(i); rd0_pair = m[0];
        rd1_idx = 4'(15 - i); rd1_pair = m[0];
        #0.5;
        check({req, (m != 0) ? " R8 p0" : " R7 p0"}, rd0_data, exp_read(i, m != 0));
        check({req, " R10 p1"}, rd1_data, exp_read(15 - i, m != 0));
      end
    end
  endtask

  // called right after a negedge; applies one write across the next posedge
  task automatic write_op(input bit en, input bit pair, input int idx, input logic [2*W-1:0] d);
    wr_en = en; wr_pair = pair; wr_idx = 4'(idx); wr_data = d;
    rd0_idx = 4'(idx); rd0_pair = pair;
    #0.5;
    check("R9 old value before edge", rd0_data, exp_read(idx, pair));
    @(posedge clk);
    if (en) begin
      if (pair) begin
        if ((idx & 14) != 0) mdl[idx & 14] = d[W-1:0];
        mdl[idx | 1] = d[2*W-1:W];
      end else if (idx != 0) begin
        mdl[idx] = d[W-1:0];
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
    #0.5;
    check("R9 new value after edge", rd0_data, exp_read(idx, pair));
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_pair = 1'b0; wr_idx = '0; wr_data = '0;
    rd0_idx = '0; rd1_idx = '0; rd0_pair = 1'b0; rd1_pair = 1'b0;
    for (int i = 0; i < N; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    sweep("R1 reset");

    // word writes to every index, including x0 (R2, R4)
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      write_op(1'b1, 1'b0, i, {32'hDEAD_0000 + 32'(i), 32'h1111_0000 + 32'(i * 7)});
    end
    sweep("R2 R4 word writes");

    // disabled writes (R3)
    for (int i = 0; i < N; i += 3) begin
      @(negedge clk);
      write_op(1'b0, i[0], i, {2*W{1'b1}});
    end
    sweep("R3 disabled");

    // pair writes, odd and even index of each pair (R5, R6)
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      write_op(1'b1, 1'b1, i, {32'hB000_0000 + 32'(i * 3), 32'hA000_0000 + 32'(i * 5)});
      sweep("R5 R6 pair write");
    end

    // word write to pair 0 with x0 index after pair writes (R4)
    @(negedge clk);
    write_op(1'b1, 1'b0, 0, {2*W{1'b1}});
    rd0_idx = 4'd0; rd0_pair = 1'b0; #0.5;
    check("R4 x0 stays zero", rd0_data, '0);

    // reset again clears everything (R1)
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0;
    for (int i = 0; i < N; i++) mdl[i] = '0;
    sweep("R1 second reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule